// File: doc/BRIEF.md
# Compare-Match Timer with Waveform Output

This block is an up-counter that restarts at a programmable compare value (clear-timer-on-compare). The counter moves forward only on cycles where the external prescaler tick is high, so the count rate is any division of the core clock. A tick that finds the counter equal to the compare value is a match event. On that tick the counter returns to zero and a sticky match flag is raised. The same event also drives one waveform output.

A 2-bit output-action field selects what a match does to the waveform: nothing (the pin stays with the port), toggle, drive low or drive high. When the field is non-zero the waveform takes the pin away from normal port logic. The output driver is enabled only when the pin's direction bit is also set. Software clears the flag by pulsing a write-one-to-clear input.

Top module: `ctc_timer`

## Requirements
- R1: A synchronous reset (rst high at a clock edge) sets the count, the match flag and the waveform output to 0.
- R2: The count rises by exactly one at a clock edge where tick_i is high and the count differs from cmp_i. At an edge where tick_i is low the count holds.
- R3: At an edge where tick_i is high and the count equals cmp_i (a match), the count becomes 0.
- R4: With cmp_i = 0 the count stays at 0, and every tick is a match.
- R5: A match sets match_flag_o at that edge. The flag stays set until an edge with flag_clr_i high. If a match and a clear fall on the same edge, the set wins.
- R6: With mode_i = 2'b01, each match inverts wave_o.
- R7: With mode_i = 2'b10 a match drives wave_o to 0. With mode_i = 2'b11 a match drives wave_o to 1.
- R8: With mode_i = 2'b00 a match leaves wave_o unchanged and pin_ovr_o is 0. For any non-zero mode_i, pin_ovr_o is 1.
- R9: pin_oe_o is 1 exactly when pin_ovr_o is 1 and dir_i is 1.
- R10: If the count is above cmp_i, it keeps counting up through 255, wraps to 0, and raises no match on the way.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous reset, active high |
| tick_i | input | 1 | Prescaled count enable |
| cmp_i | input | 8 | Compare value (TOP) |
| mode_i | input | 2 | Output action: 00 off, 01 toggle, 10 clear, 11 set |
| dir_i | input | 1 | Pin direction bit (1 = output) |
| flag_clr_i | input | 1 | Write-one-to-clear for the match flag |
| count_o | output | 8 | Current count |
| match_flag_o | output | 1 | Sticky compare-match flag |
| wave_o | output | 1 | Waveform output |
| pin_ovr_o | output | 1 | Waveform overrides the port function of the pin |
| pin_oe_o | output | 1 | Output driver enable for the pin |

## Verification
Two functions can land on the same edge: the flag's set from a match and its clear from software. The bench uses a compare value of 0, so every tick is a match, and raises tick and clear together. It then expects the flag to read 1, and a following clear-only cycle to read 0. A second collision comes from changing mode_i between matches. Each match must apply the action of the mode present on that edge.

// File: rtl/ctc_pkg.sv
package ctc_pkg;

    typedef enum logic [1:0] {
        ACT_OFF    = 2'b00,
        ACT_TOGGLE = 2'b01,
        ACT_CLEAR  = 2'b10,
        ACT_SET    = 2'b11
    } act_mode_e;

    typedef struct packed {
        logic flag;
        logic wave;
    } out_state_t;

endpackage

// File: rtl/ctc_count.sv
module ctc_count #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] top_i,
    output logic [WIDTH-1:0] cnt_o,
    output logic             hit_o
);
    localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } cnt_state_t;

    cnt_state_t state_d, state_q;
    logic       at_top;

    always_comb begin
        state_d = state_q;
        at_top  = (state_q.cnt == top_i);
        hit_o   = tick_i && at_top;
        if (tick_i) begin
            if (at_top) state_d.cnt = '0;
            else        state_d.cnt = state_q.cnt + ONE;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign cnt_o = state_q.cnt;
endmodule

// File: rtl/ctc_outunit.sv
module ctc_outunit
    import ctc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       hit_i,
    input  logic       clr_i,
    input  logic [1:0] mode_i,
    output logic       flag_o,
    output logic       wave_o,
    output logic       ovr_o
);
    out_state_t state_d, state_q;
    act_mode_e  mode;

    always_comb begin
        mode    = act_mode_e'(mode_i);
        state_d = state_q;
        if (clr_i) state_d.flag = 1'b0;
        if (hit_i) begin
            state_d.flag = 1'b1;
            unique case (mode)
                ACT_TOGGLE: state_d.wave = ~state_q.wave;
                ACT_CLEAR:  state_d.wave = 1'b0;
                ACT_SET:    state_d.wave = 1'b1;
                default:    state_d.wave = state_q.wave;
            endcase
        end
        ovr_o = (mode != ACT_OFF);
    end

    always_ff @(posedge clk) begin
        if (rst) state_q <= '0;
        else     state_q <= state_d;
    end

    assign flag_o = state_q.flag;
    assign wave_o = state_q.wave;
endmodule

// File: rtl/ctc_timer.sv
module ctc_timer #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick_i,
    input  logic [WIDTH-1:0] cmp_i,
    input  logic [1:0]       mode_i,
    input  logic             dir_i,
    input  logic             flag_clr_i,
    output logic [WIDTH-1:0] count_o,
    output logic             match_flag_o,
    output logic             wave_o,
    output logic             pin_ovr_o,
    output logic             pin_oe_o
);
    logic hit;

    ctc_count #(.WIDTH(WIDTH)) u_count (
        .clk    (clk),
        .rst    (rst),
        .tick_i (tick_i),
        .top_i  (cmp_i),
        .cnt_o  (count_o),
        .hit_o  (hit)
    );

    ctc_outunit u_out (
        .clk    (clk),
        .rst    (rst),
        .hit_i  (hit),
        .clr_i  (flag_clr_i),
        .mode_i (mode_i),
        .flag_o (match_flag_o),
        .wave_o (wave_o),
        .ovr_o  (pin_ovr_o)
    );

    assign pin_oe_o = pin_ovr_o & dir_i;
endmodule

// File: rtl/ctc_timer_chk.sv
module ctc_timer_chk #(
    parameter int WIDTH = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             tick_i,
    input logic [WIDTH-1:0] cmp_i,
    input logic [1:0]       mode_i,
    input logic             dir_i,
    input logic             flag_clr_i,
    input logic [WIDTH-1:0] count_o,
    input logic             match_flag_o,
    input logic             wave_o,
    input logic             pin_ovr_o,
    input logic             pin_oe_o
);
    AST_COUNT_STEP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o != cmp_i) |=> count_o == WIDTH'($past(count_o) + 1)); // R2
    AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !tick_i |=> $stable(count_o)); // R2
    AST_TOP_WRAP: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o == cmp_i) |=> count_o == '0); // R3
    AST_FLAG_SET: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o == cmp_i) |=> match_flag_o); // R5
    AST_FLAG_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (flag_clr_i && !(tick_i && count_o == cmp_i)) |=> !match_flag_o); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        (match_flag_o && !flag_clr_i) |=> match_flag_o); // R5
    AST_WAVE_TOGGLE: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o == cmp_i && mode_i == 2'b01) |=> wave_o != $past(wave_o)); // R6
    AST_WAVE_SET: assert property (@(posedge clk) disable iff (rst)
        (tick_i && count_o == cmp_i && mode_i == 2'b11) |=> wave_o); // R7
    AST_WAVE_OFF: assert property (@(posedge clk) disable iff (rst)
        (mode_i == 2'b00) |=> $stable(wave_o)); // R8
    AST_PIN_ENABLE: assert property (@(posedge clk) disable iff (rst)
        pin_oe_o |-> (dir_i && mode_i != 2'b00)); // R9
endmodule

bind ctc_timer ctc_timer_chk #(.WIDTH(WIDTH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .tick_i       (tick_i),
    .cmp_i        (cmp_i),
    .mode_i       (mode_i),
    .dir_i        (dir_i),
    .flag_clr_i   (flag_clr_i),
    .count_o      (count_o),
    .match_flag_o (match_flag_o),
    .wave_o       (wave_o),
    .pin_ovr_o    (pin_ovr_o),
    .pin_oe_o     (pin_oe_o)
);

// File: tb/ctc_timer_tb.sv
module ctc_timer_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick_i = 1'b0;
    logic [7:0] cmp_i = 8'd0;
    logic [1:0] mode_i = 2'b00;
    logic       dir_i = 1'b0;
    logic       flag_clr_i = 1'b0;
    logic [7:0] count_o;
    logic       match_flag_o, wave_o, pin_ovr_o, pin_oe_o;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    always #4 clk = ~clk;

    ctc_timer u_dut (
        .clk(clk), .rst(rst), .tick_i(tick_i), .cmp_i(cmp_i), .mode_i(mode_i),
        .dir_i(dir_i), .flag_clr_i(flag_clr_i), .count_o(count_o),
        .match_flag_o(match_flag_o), .wave_o(wave_o), .pin_ovr_o(pin_ovr_o),
        .pin_oe_o(pin_oe_o)
    );

    task automatic chk(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // one clock: inputs driven after a falling edge, outputs read at the next falling edge
    task automatic cyc(bit t, bit c = 1'b0);
        tick_i = t;
        flag_clr_i = c;
        @(negedge clk);
        tick_i = 1'b0;
        flag_clr_i = 1'b0;
    endtask

    task automatic do_reset();
        tick_i = 0; flag_clr_i = 0; rst = 1;
        @(negedge clk); @(negedge clk);
        rst = 0;
    endtask

    task automatic t_reset();
        tick_i = 1; mode_i = 2'b11; cmp_i = 8'd0;
        rst = 1;
        @(negedge clk); @(negedge clk);
        chk("R1 count", count_o, 0);
        chk("R1 flag", match_flag_o, 0);
        chk("R1 wave", wave_o, 0);
        rst = 0; tick_i = 0; mode_i = 2'b00;
    endtask

    task automatic t_count_wrap();
        do_reset();
        cmp_i = 8'd3; mode_i = 2'b01;
        cyc(1); chk("R2 step1", count_o, 1);
        cyc(1); chk("R2 step2", count_o, 2);
        cyc(0); cyc(0); chk("R2 hold", count_o, 2);
        cyc(1); chk("R2 step3", count_o, 3);
        chk("R5 no flag before match", match_flag_o, 0);
        cyc(1); chk("R3 wrap at top", count_o, 0);
        chk("R5 flag on match", match_flag_o, 1);
        chk("R6 toggle to 1", wave_o, 1);
        cyc(0); chk("R5 flag sticky", match_flag_o, 1);
        for (int i = 0; i < 4; i++) cyc(1);
        chk("R6 toggle back to 0", wave_o, 0);
        chk("R3 second wrap", count_o, 0);
    endtask

    task automatic t_prescale();
        do_reset();
        cmp_i = 8'd200; mode_i = 2'b00;
        for (int k = 0; k < 5; k++) begin
            cyc(1);
            for (int j = 0; j < 7; j++) cyc(0);
        end
        chk("R2 prescaled count", count_o, 5);
    endtask

    task automatic t_flag_priority();
        do_reset();
        cmp_i = 8'd0; mode_i = 2'b00;
        cyc(1); chk("R5 set", match_flag_o, 1);
        cyc(0, 1); chk("R5 clear", match_flag_o, 0);
        cyc(1, 1); chk("R5 set wins over clear", match_flag_o, 1);
        cyc(0, 1); chk("R5 clear after collision", match_flag_o, 0);
    endtask

    task automatic t_cmp_zero();
        do_reset();
        cmp_i = 8'd0; mode_i = 2'b01;
        cyc(1); chk("R4 count stays 0", count_o, 0);
        chk("R4 match each tick a", wave_o, 1);
        cyc(0, 1);
        cyc(1); chk("R4 count stays 0 b", count_o, 0);
        chk("R4 match each tick b", match_flag_o, 1);
        chk("R4 toggle again", wave_o, 0);
    endtask

    task automatic t_modes();
        do_reset();
        cmp_i = 8'd0;
        mode_i = 2'b11; cyc(1); chk("R7 set", wave_o, 1);
        cyc(1); chk("R7 set holds high", wave_o, 1);
        mode_i = 2'b10; cyc(1); chk("R7 clear", wave_o, 0);
        mode_i = 2'b00; cyc(1); chk("R8 off keeps 0", wave_o, 0);
        mode_i = 2'b11; cyc(1);
        mode_i = 2'b00; cyc(1); chk("R8 off keeps 1", wave_o, 1);
    endtask

    task automatic t_pin();
        mode_i = 2'b00; dir_i = 1; #1;
        chk("R8 no override", pin_ovr_o, 0);
        chk("R9 oe off mode", pin_oe_o, 0);
        mode_i = 2'b10; dir_i = 0; #1;
        chk("R8 override", pin_ovr_o, 1);
        chk("R9 oe needs dir", pin_oe_o, 0);
        dir_i = 1; #1;
        chk("R9 oe on", pin_oe_o, 1);
        mode_i = 2'b01; #1;
        chk("R8 override toggle mode", pin_ovr_o, 1);
        dir_i = 0; mode_i = 2'b00;
        @(negedge clk);
    endtask

    task automatic t_above_top();
        do_reset();
        cmp_i = 8'd100; mode_i = 2'b00;
        for (int i = 0; i < 50; i++) cyc(1);
        cmp_i = 8'd10;
        for (int i = 0; i < 205; i++) cyc(1);
        chk("R10 reaches 255", count_o, 255);
        chk("R10 no match", match_flag_o, 0);
        cyc(1); chk("R10 wraps to 0", count_o, 0);
        chk("R10 still no match", match_flag_o, 0);
        for (int i = 0; i < 10; i++) cyc(1);
        chk("R10 reaches top", count_o, 10);
        cyc(1); chk("R3 wrap after overflow", count_o, 0);
        chk("R5 flag after overflow", match_flag_o, 1);
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        t_reset();
        t_count_wrap();
        t_prescale();
        t_flag_priority();
        t_cmp_zero();
        t_modes();
        t_pin();
        t_above_top();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule